// File: doc/BRIEF.md
# Distributed CAS-before-RAS Refresh and Start-up Scheduler

This block sits beside the access controller of an asynchronous-strobe DRAM and looks after the two duties that keep the array alive. After reset it waits out the power-up pause, then issues a burst of CAS-before-RAS refresh cycles. Only after that burst does it raise `init_done`, which tells the access controller that normal traffic may begin. From then on an interval timer earns one refresh credit per refresh period. Each credit is spent on one CAS-before-RAS cycle. The DRAM's own row counter picks the row, so the block drives no address.

The block runs the strobes only while it holds the bus. During the start-up burst it owns the bus outright. In normal operation it raises `rfsh_req` and waits for `rfsh_gnt`. The access controller must keep `rfsh_gnt` high until `rfsh_req` falls. While the controller is busy, credits queue up to `MAX_PENDING`; `urgent` then tells the controller to grant at the next opportunity. Any tick that arrives while the queue is full is dropped. Write enable and output enable are held inactive throughout, so the data pins stay undriven during every refresh. The access controller multiplexes this block's strobes onto the pins whenever `own_bus` is high.

All timings are parameters counted in system clocks. These are the pause, the burst length, the refresh interval, the CAS lead, the RAS low time, the CAS hold after RAS falls, and the precharge. A longer retention period is therefore only a change of `INTERVAL_CYC`.

Top module: `cbr_refresh_sched`

## Requirements
- R1: After reset `ras_n`, `cas_n` are high, `rfsh_req`, `own_bus`, `init_done` are low and `pend_cnt` is 0; the first CAS fall comes no earlier than `INIT_PAUSE_CYC` and no later than `INIT_PAUSE_CYC`+2 cycles after reset release.
- R2: After the pause exactly `INIT_BURST` refresh cycles run before `init_done` rises; `rfsh_req` stays low while `init_done` is low, and `init_done` never falls again until reset.
- R3: In each refresh cycle `cas_n` is low for exactly `CSR_CYC` cycles before `ras_n` falls. `ras_n` then stays low exactly `RAS_CYC` cycles. `cas_n` rises exactly `CHR_CYC` cycles after `ras_n` falls. Both strobes are high for at least `RP_CYC` cycles before the next CAS fall.
- R4: `we_n` and `oe_n` stay high at all times (1 = inactive), so no write occurs and the data pins are never driven during refresh.
- R5: `ras_n` or `cas_n` is low only while `own_bus` is high.
- R6: After `init_done` rises, one credit is added every `INTERVAL_CYC` cycles; the first is added `INTERVAL_CYC` cycles after `init_done` rises.
- R7: With credits pending, `rfsh_req` is high and is held until granted. No refresh runs without a grant. Each granted request runs one refresh cycle and removes one credit.
- R8: `pend_cnt` never exceeds `MAX_PENDING`; ticks arriving when it is full are dropped; `urgent` is 1 exactly when `pend_cnt` equals `MAX_PENDING`.
- R9: When grants come promptly, the queue empties within half an interval, and exactly one refresh runs per interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_gnt | input | 1 | Bus grant from the access controller, held while `rfsh_req` is high |
| rfsh_req | output | 1 | Refresh bus request |
| own_bus | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| init_done | output | 1 | Start-up sequence complete |
| pend_cnt | output | PEND_W | Number of refresh credits waiting |
| urgent | output | 1 | Credit queue is full |

## Verification
Strobes change one clock after the grant or start condition that triggers them. Each strobe phase is measured in whole cycles at the falling clock edge and compared with its parameter. Credits land on edges that are multiples of `INTERVAL_CYC` counted from `init_done`. The bench therefore samples `pend_cnt`, `urgent`, `rfsh_req` and the refresh count only at mid-interval points, where no tick or refresh completion can be in flight. Random stretches with the grant withheld for 0 to 4 intervals give queue depths that the bench predicts, including saturation. A recovery window of two intervals follows each stretch, and the expected refresh count for it is worked out in advance.

// File: rtl/cbr_sched_pkg.sv
package cbr_sched_pkg;
  typedef enum logic [2:0] {
    SC_PAUSE,
    SC_BURST,
    SC_IDLE,
    SC_REQ,
    SC_RUN
  } sched_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int INTERVAL_CYC = 1560,
  localparam int TW = $clog2(INTERVAL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [TW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= TW'(INTERVAL_CYC - 1);
    end else if (!run || tick) begin
      cnt <= TW'(INTERVAL_CYC - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int MAX_PENDING = 8,
  localparam int PEND_W = $clog2(MAX_PENDING + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add,
  input  logic              take,
  output logic [PEND_W-1:0] count,
  output logic              full
);
  assign full = (count == PEND_W'(MAX_PENDING));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (add && !take) begin
      if (!full) count <= count + 1'b1;
    end else if (take && !add) begin
      if (count != '0) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_sched_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int RAS_CYC = 6,
  parameter int CHR_CYC = 2,
  parameter int RP_CYC  = 4,
  localparam int MAXC = max_of4(CSR_CYC, RAS_CYC, CHR_CYC, RP_CYC),
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  seq_state_e    st;
  logic [CW-1:0] cnt;

  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st    <= SQ_SETUP;
            cnt   <= CW'(CSR_CYC - 1);
            cas_n <= 1'b0;
          end
        end
        SQ_SETUP: begin
          if (cnt == '0) begin
            st    <= SQ_ACT;
            cnt   <= CW'(RAS_CYC - 1);
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_ACT: begin
          // cycles RAS has been low, including this one
          if ((CW'(RAS_CYC) - cnt) >= CW'(CHR_CYC)) cas_n <= 1'b1;
          if (cnt == '0) begin
            st    <= SQ_PRE;
            cnt   <= CW'(RP_CYC - 1);
            ras_n <= 1'b1;
            cas_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_PRE: begin
          if (cnt == '0) begin
            st   <= SQ_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_sched_pkg::*;
#(
  parameter int INIT_PAUSE_CYC = 20000,
  parameter int INIT_BURST     = 8,
  parameter int INTERVAL_CYC   = 1560,
  parameter int MAX_PENDING    = 8,
  parameter int CSR_CYC        = 1,
  parameter int RAS_CYC        = 6,
  parameter int CHR_CYC        = 2,
  parameter int RP_CYC         = 4,
  localparam int PEND_W = $clog2(MAX_PENDING + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh_gnt,
  output logic              rfsh_req,
  output logic              own_bus,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              init_done,
  output logic [PEND_W-1:0] pend_cnt,
  output logic              urgent
);
  localparam int PW = $clog2(INIT_PAUSE_CYC + 1);
  localparam int BW = $clog2(INIT_BURST + 1);

  sched_state_e  state;
  logic [PW-1:0] pause_cnt;
  logic [BW-1:0] burst_cnt;
  logic          seq_start, seq_busy, seq_done;
  logic          tick, take;

  assign seq_start = ((state == SC_BURST) && !seq_busy && !seq_done) ||
                     ((state == SC_REQ) && rfsh_gnt);
  assign take      = (state == SC_RUN) && seq_done;
  assign rfsh_req  = (state == SC_REQ) || (state == SC_RUN);
  assign own_bus   = (state == SC_BURST) || (state == SC_RUN);
  assign we_n      = 1'b1;
  assign oe_n      = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SC_PAUSE;
      pause_cnt <= PW'(INIT_PAUSE_CYC - 1);
      burst_cnt <= '0;
      init_done <= 1'b0;
    end else begin
      case (state)
        SC_PAUSE: begin
          if (pause_cnt == '0) state <= SC_BURST;
          else                 pause_cnt <= pause_cnt - 1'b1;
        end
        SC_BURST: begin
          if (seq_done) begin
            if (burst_cnt == BW'(INIT_BURST - 1)) begin
              state     <= SC_IDLE;
              init_done <= 1'b1;
            end else begin
              burst_cnt <= burst_cnt + 1'b1;
            end
          end
        end
        SC_IDLE: if (pend_cnt != '0) state <= SC_REQ;
        SC_REQ:  if (rfsh_gnt) state <= SC_RUN;
        SC_RUN:  if (seq_done) state <= SC_IDLE;
        default: state <= SC_IDLE;
      endcase
    end
  end

  rfsh_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (init_done),
    .tick (tick)
  );

  rfsh_credit #(.MAX_PENDING(MAX_PENDING)) u_credit (
    .clk  (clk),
    .rst_n(rst_n),
    .add  (tick),
    .take (take),
    .count(pend_cnt),
    .full (urgent)
  );

  cbr_seq #(
    .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC),
    .CHR_CYC(CHR_CYC),
    .RP_CYC (RP_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(seq_start),
    .busy (seq_busy),
    .done (seq_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int MAX_PENDING = 8,
  parameter int PEND_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rfsh_gnt,
  input logic              rfsh_req,
  input logic              own_bus,
  input logic              ras_n,
  input logic              cas_n,
  input logic              init_done,
  input logic [PEND_W-1:0] pend_cnt
);
  a_r2_no_req_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !rfsh_req);

  a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r3_cas_low_at_ras_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  a_r5_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> own_bus);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_gnt) |=> rfsh_req);

  a_r8_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= MAX_PENDING);
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .MAX_PENDING(MAX_PENDING),
  .PEND_W     (PEND_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rfsh_gnt (rfsh_gnt),
  .rfsh_req (rfsh_req),
  .own_bus  (own_bus),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .init_done(init_done),
  .pend_cnt (pend_cnt)
);

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_PAUSE = 30;
  localparam int T_BURST = 8;
  localparam int T_INT   = 60;
  localparam int T_MAX   = 3;
  localparam int T_CSR   = 1;
  localparam int T_RAS   = 6;
  localparam int T_CHR   = 2;
  localparam int T_RP    = 4;
  localparam int HALF    = T_INT / 2;
  localparam int PW      = $clog2(T_MAX + 1);
  localparam int WDOG    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_gnt = 1'b0;
  logic rfsh_req, own_bus, ras_n, cas_n, we_n, oe_n, init_done, urgent;
  logic [PW-1:0] pend_cnt;

  int checks = 0;
  int fails = 0;
  int mode = 0;  // 0 withhold, 1 immediate, 2 random delay
  int dly = -1;

  // monitor state
  int cyc = 0, m = 0, falls = 0, post_falls = 0, first_cas = -1;
  int cas_run = 0, ras_low = 0, chr = 0, hi_run = 0;
  bit ras_q = 1'b1, cas_q = 1'b1, seen_cycle = 1'b0, early_req = 1'b0;
  int own_viol = 0, wo_viol = 0, over_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_refresh_sched #(
    .INIT_PAUSE_CYC(T_PAUSE), .INIT_BURST(T_BURST), .INTERVAL_CYC(T_INT),
    .MAX_PENDING(T_MAX), .CSR_CYC(T_CSR), .RAS_CYC(T_RAS),
    .CHR_CYC(T_CHR), .RP_CYC(T_RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
    .own_bus(own_bus), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .init_done(init_done), .pend_cnt(pend_cnt), .urgent(urgent)
  );

  function automatic int exp_pend(input int ticks);
    return (ticks > T_MAX) ? T_MAX : ticks;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!init_done && rfsh_req) early_req = 1'b1;
      if (init_done) m++;
      if ((!ras_n || !cas_n) && !own_bus) own_viol++;
      if (!we_n || !oe_n) wo_viol++;
      if (int'(pend_cnt) > T_MAX || urgent != (int'(pend_cnt) == T_MAX)) over_viol++;
      if (cas_q && !cas_n) begin
        if (first_cas < 0) first_cas = cyc;
        if (seen_cycle) check(hi_run >= T_RP, "R3 precharge cycles", hi_run, T_RP);
        hi_run = 0;
      end
      if (ras_q && !ras_n) begin
        falls++;
        if (init_done) post_falls++;
        check(cas_run == T_CSR, "R3 CAS lead cycles", cas_run, T_CSR);
        chr = 0;
        ras_low = 0;
        seen_cycle = 1'b1;
      end
      if (!ras_q && ras_n) check(ras_low == T_RAS, "R3 RAS low cycles", ras_low, T_RAS);
      if (!cas_q && cas_n && (!ras_n || !ras_q))
        check(chr == T_CHR, "R3 CAS hold after RAS fall", chr, T_CHR);
      if (!ras_n) ras_low++;
      if (!ras_n && !cas_n) chr++;
      if (!cas_n && ras_n) cas_run++;
      else if (cas_n) cas_run = 0;
      if (ras_n && cas_n) hi_run++;
      ras_q = ras_n;
      cas_q = cas_n;
    end
  end

  // access controller model
  always begin
    @(negedge clk);
    #2;
    if (!rst_n || !rfsh_req) begin
      rfsh_gnt = 1'b0;
      dly = -1;
    end else if (!rfsh_gnt) begin
      if (mode == 1) rfsh_gnt = 1'b1;
      else if (mode == 2) begin
        if (dly < 0) dly = int'($urandom % 8);
        if (dly == 0) rfsh_gnt = 1'b1;
        else dly--;
      end
    end
  end

  task automatic wait_k(input int k);
    while (m - 1 < k) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    int base, e, n, kk;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(ras_n && cas_n, "R1 strobes high after reset", {ras_n, cas_n}, 3);
    check(!rfsh_req && !own_bus && !init_done, "R1 req/own/init low",
          {rfsh_req, own_bus, init_done}, 0);
    check(pend_cnt == '0, "R1 pend zero", int'(pend_cnt), 0);
    while (!init_done) begin
      @(negedge clk);
      #1;
    end
    check(first_cas >= T_PAUSE && first_cas <= T_PAUSE + 2, "R1 pause before first CAS",
          first_cas, T_PAUSE + 1);
    check(falls == T_BURST, "R2 start-up burst length", falls, T_BURST);
    check(!early_req, "R2 no request before init_done", int'(early_req), 0);

    // withhold grant: credits accumulate and saturate (R6, R7, R8)
    mode = 0;
    for (int j = 0; j <= 5; j++) begin
      wait_k(j * T_INT + HALF);
      e = exp_pend(j);
      check(int'(pend_cnt) == e, "R6 credit count while withheld", int'(pend_cnt), e);
      check(urgent == (e == T_MAX), "R8 urgent flag", int'(urgent), int'(e == T_MAX));
      check(rfsh_req == (e > 0), "R7 request while credit pending", int'(rfsh_req), int'(e > 0));
      check(post_falls == 0, "R7 no refresh without grant", post_falls, 0);
    end

    // immediate grants drain the backlog (R7, R9)
    mode = 1;
    base = post_falls;
    wait_k(6 * T_INT + HALF);
    check(pend_cnt == '0, "R9 queue drained", int'(pend_cnt), 0);
    check(post_falls - base == T_MAX + 1, "R7 one refresh per credit", post_falls - base, T_MAX + 1);
    check(!rfsh_req, "R7 request released", int'(rfsh_req), 0);

    // random busy stretches followed by random-latency recovery
    kk = 6;
    for (int r = 0; r < 10; r++) begin
      n = int'($urandom % 5);
      mode = 0;
      base = post_falls;
      wait_k((kk + n) * T_INT + HALF);
      e = exp_pend(n);
      check(int'(pend_cnt) == e, "R8 queue depth after busy stretch", int'(pend_cnt), e);
      check(urgent == (e == T_MAX), "R8 urgent after busy stretch", int'(urgent), int'(e == T_MAX));
      check(post_falls == base, "R7 no refresh while withheld", post_falls - base, 0);
      mode = 2;
      wait_k((kk + n + 2) * T_INT + HALF);
      check(pend_cnt == '0, "R9 recovered queue empty", int'(pend_cnt), 0);
      check(post_falls - base == e + 2, "R9 refresh count in recovery", post_falls - base, e + 2);
      kk = kk + n + 2;
    end

    check(own_viol == 0, "R5 strobes only while own_bus", own_viol, 0);
    check(wo_viol == 0, "R4 we_n/oe_n held high", wo_viol, 0);
    check(over_viol == 0, "R8 bound and urgent per cycle", over_viol, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    summary();
    $finish;
  end
endmodule